// File: doc/BRIEF.md
# Cross-warp cache-line request merger

This block collects single cache-line requests from several upstream per-warp coalescers and folds requests for the same line into one entry, even when they come from different warps. Each request carries a line address, a warp identifier and a lane mask. The low bits of the line address pick one of many small queues. Inside that queue the remaining upper bits are compared against a handful of stored tags. A match appends the request to the existing entry. A miss takes a free slot.

Every entry keeps its line, the number of merged records, up to a fixed number of (warp, lane mask) records and the value of a free-running stamp taken when it was allocated. All entries are visible to an external selector. When the selector names an entry on the grant port, the block shows that entry's contents on the same cycle and frees the slot at the next clock edge. Requests that cannot be placed are held back with ready low. They are never dropped.

Top module: `iwc_coalescer`

## Requirements
- R1: After synchronous reset no entry is valid, and a grant produces `out_valid` low.
- R2: A request's queue is `line % QUEUES` (bits [4:0] with 32 queues), and its tag is the remaining upper bits. Entry index = queue*SLOTS + slot, and `ent_line` shows the full line of each valid entry.
- R3: A request whose tag matches a valid entry in its queue is appended as record number `count` of that entry. The count rises by one and no new entry is created.
- R4: A request with no match takes the lowest-numbered free slot of its queue. The new entry has count 1, its first record is the request, and its stamp is the current counter value.
- R5: Each queue accepts at most one insertion per cycle. When several valid ports target the same queue, the lowest-numbered port is accepted and the others see `in_ready` low.
- R6: A request that matches an entry already holding MAXW (4) records gets `in_ready` low and leaves all entries unchanged.
- R7: A request with no match in a queue whose slots are all valid gets `in_ready` low and leaves all entries unchanged.
- R8: `in_ready[p]` is high only while `in_valid[p]` is high and the request is taken at that clock edge.
- R9: With `gnt_valid` high on a valid entry, `out_valid`, `out_line`, `out_count`, `out_warp[k]` and `out_mask[k]` (for k < count, in merge order) show that entry in the same cycle, and the entry is invalid after the edge.
- R10: A grant that names an invalid entry gives `out_valid` low and changes no entry.
- R11: An entry under grant is excluded from tag matching in that cycle. A request for its line then takes another free slot of the queue as a fresh entry, and the granted output does not include it.
- R12: The stamp counter starts at 0 after reset and rises by one each cycle, so two entries allocated k cycles apart differ in stamp by k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | PORTS | Request present per port |
| in_line | input | PORTS x LINE_W | Cache-line address per port |
| in_warp | input | PORTS x WID_W | Warp identifier per port |
| in_mask | input | PORTS x LANES | Lane mask per port |
| in_ready | output | PORTS | Request taken this cycle |
| ent_valid | output | ENTRIES | Entry occupancy |
| ent_line | output | ENTRIES x LINE_W | Line address of each entry |
| ent_stamp | output | ENTRIES x STAMP_W | Allocation stamp of each entry |
| gnt_valid | input | 1 | Selector grants an entry |
| gnt_idx | input | ENT_W | Entry being granted |
| out_valid | output | 1 | Granted entry was valid |
| out_line | output | LINE_W | Line of granted entry |
| out_count | output | CNT_W | Records in granted entry |
| out_warp | output | MAXW x WID_W | Warp per record |
| out_mask | output | MAXW x LANES | Lane mask per record |

## Verification
Removal by grant and a matching insertion can fall on the same entry in one cycle. If the merge were allowed, the new record would leave with the entry and be lost. The bench grants a live entry while a request for the same line is presented. It checks that the granted contents do not include the new request, that `in_ready` is high, and that the request appears afterwards as a separate one-record entry in the other slot of that queue. Port collisions on one queue in the same cycle are also provoked and checked through `in_ready`.

// File: rtl/iwc_pkg.sv
package iwc_pkg;
    // Configuration; QUEUES, SLOTS and MAXW are powers of two, SLOTS >= 2.
    parameter int unsigned PORTS   = 2;
    parameter int unsigned QUEUES  = 32;
    parameter int unsigned SLOTS   = 2;
    parameter int unsigned MAXW    = 4;
    parameter int unsigned LINE_W  = 16;
    parameter int unsigned WID_W   = 6;
    parameter int unsigned LANES   = 32;
    parameter int unsigned STAMP_W = 16;

    localparam int unsigned QIDX_W  = $clog2(QUEUES);
    localparam int unsigned TAG_W   = LINE_W - QIDX_W;
    localparam int unsigned SLOT_W  = $clog2(SLOTS);
    localparam int unsigned REC_W   = $clog2(MAXW);
    localparam int unsigned CNT_W   = $clog2(MAXW + 1);
    localparam int unsigned ENTRIES = QUEUES * SLOTS;
    localparam int unsigned ENT_W   = QIDX_W + SLOT_W;
    localparam int unsigned PORT_W  = (PORTS > 1) ? $clog2(PORTS) : 1;

    typedef struct packed {
        logic [WID_W-1:0] warp;
        logic [LANES-1:0] mask;
    } rec_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        rec_t             rec;
    } req_t;

    function automatic logic [QIDX_W-1:0] qidx_of(input logic [LINE_W-1:0] line);
        return line[QIDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [LINE_W-1:0] line);
        return line[LINE_W-1:QIDX_W];
    endfunction
endpackage

// File: rtl/iwc_route.sv
module iwc_route
    import iwc_pkg::*;
(
    input  logic [PORTS-1:0]                 in_valid,
    input  logic [PORTS-1:0][LINE_W-1:0]     in_line,
    output logic [QUEUES-1:0]                q_any,
    output logic [QUEUES-1:0][PORT_W-1:0]    q_sel,
    output logic [PORTS-1:0]                 win
);
    // Lowest valid port wins each queue (descending scan, last write wins).
    always_comb begin
        q_any = '0;
        q_sel = '0;
        for (int q = 0; q < int'(QUEUES); q++) begin
            for (int p = int'(PORTS) - 1; p >= 0; p--) begin
                if (in_valid[p] && qidx_of(in_line[p]) == QIDX_W'(q)) begin
                    q_any[q] = 1'b1;
                    q_sel[q] = PORT_W'(p);
                end
            end
        end
    end

    always_comb begin
        for (int p = 0; p < int'(PORTS); p++) begin
            win[p] = in_valid[p] && (q_sel[qidx_of(in_line[p])] == PORT_W'(p));
        end
    end
endmodule

// File: rtl/iwc_queue.sv
module iwc_queue
    import iwc_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               req_valid,
    input  req_t                               req,
    input  logic                               gnt_valid,
    input  logic [SLOT_W-1:0]                  gnt_slot,
    input  logic [STAMP_W-1:0]                 stamp_now,
    output logic                               req_ok,
    output logic [SLOTS-1:0]                   ent_v,
    output logic [SLOTS-1:0][TAG_W-1:0]        ent_tag,
    output logic [SLOTS-1:0][CNT_W-1:0]        ent_cnt,
    output logic [SLOTS-1:0][STAMP_W-1:0]      ent_stamp,
    output rec_t [SLOTS-1:0][MAXW-1:0]         ent_rec
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MAXW);

    logic [SLOTS-1:0]                  v_q;
    logic [SLOTS-1:0][TAG_W-1:0]       tag_q;
    logic [SLOTS-1:0][CNT_W-1:0]       cnt_q;
    logic [SLOTS-1:0][STAMP_W-1:0]     stamp_q;
    rec_t [SLOTS-1:0][MAXW-1:0]        rec_q;

    logic              hit, free_found;
    logic [SLOT_W-1:0] hit_slot, free_slot;
    logic              take;

    // Tag lookup; a slot under grant this cycle does not match.
    always_comb begin
        hit        = 1'b0;
        hit_slot   = '0;
        free_found = 1'b0;
        free_slot  = '0;
        for (int s = 0; s < int'(SLOTS); s++) begin
            if (v_q[s] && tag_q[s] == req.tag && !(gnt_valid && gnt_slot == SLOT_W'(s))) begin
                hit      = 1'b1;
                hit_slot = SLOT_W'(s);
            end
        end
        for (int s = int'(SLOTS) - 1; s >= 0; s--) begin
            if (!v_q[s]) begin
                free_found = 1'b1;
                free_slot  = SLOT_W'(s);
            end
        end
        req_ok = hit ? (cnt_q[hit_slot] != CNT_FULL) : free_found;
    end

    assign take = req_valid && req_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q     <= '0;
            tag_q   <= '0;
            cnt_q   <= '0;
            stamp_q <= '0;
            rec_q   <= '0;
        end else begin
            if (gnt_valid) v_q[gnt_slot] <= 1'b0;
            if (take) begin
                if (hit) begin
                    rec_q[hit_slot][cnt_q[hit_slot][REC_W-1:0]] <= req.rec;
                    cnt_q[hit_slot] <= cnt_q[hit_slot] + CNT_W'(1);
                end else begin
                    v_q[free_slot]      <= 1'b1;
                    tag_q[free_slot]    <= req.tag;
                    cnt_q[free_slot]    <= CNT_W'(1);
                    stamp_q[free_slot]  <= stamp_now;
                    rec_q[free_slot][0] <= req.rec;
                end
            end
        end
    end

    assign ent_v     = v_q;
    assign ent_tag   = tag_q;
    assign ent_cnt   = cnt_q;
    assign ent_stamp = stamp_q;
    assign ent_rec   = rec_q;

    // R3: a merge grows the matched entry by exactly one record
    assert_merge_grows_R3: assert property (@(posedge clk) disable iff (rst)
        (take && hit) |=> (cnt_q[$past(hit_slot)] == $past(cnt_q[hit_slot]) + CNT_W'(1)));

    // R4: an allocation yields a valid one-record entry
    assert_alloc_fresh_R4: assert property (@(posedge clk) disable iff (rst)
        (take && !hit) |=> (v_q[$past(free_slot)] && cnt_q[$past(free_slot)] == CNT_W'(1)));

    // R6: a live entry never exceeds its record capacity
    for (genvar s = 0; s < SLOTS; s++) begin : g_cap
        assert_cnt_cap_R6: assert property (@(posedge clk) disable iff (rst)
            v_q[s] |-> (cnt_q[s] != '0 && cnt_q[s] <= CNT_FULL));
    end
endmodule

// File: rtl/iwc_coalescer.sv
module iwc_coalescer
    import iwc_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic [PORTS-1:0]                   in_valid,
    input  logic [PORTS-1:0][LINE_W-1:0]       in_line,
    input  logic [PORTS-1:0][WID_W-1:0]        in_warp,
    input  logic [PORTS-1:0][LANES-1:0]        in_mask,
    output logic [PORTS-1:0]                   in_ready,
    output logic [ENTRIES-1:0]                 ent_valid,
    output logic [ENTRIES-1:0][LINE_W-1:0]     ent_line,
    output logic [ENTRIES-1:0][STAMP_W-1:0]    ent_stamp,
    input  logic                               gnt_valid,
    input  logic [ENT_W-1:0]                   gnt_idx,
    output logic                               out_valid,
    output logic [LINE_W-1:0]                  out_line,
    output logic [CNT_W-1:0]                   out_count,
    output logic [MAXW-1:0][WID_W-1:0]         out_warp,
    output logic [MAXW-1:0][LANES-1:0]         out_mask
);
    logic [STAMP_W-1:0]                         stamp;
    logic [QUEUES-1:0]                          q_any, q_ok;
    logic [QUEUES-1:0][PORT_W-1:0]              q_sel;
    logic [PORTS-1:0]                           win;
    logic [QUEUES-1:0][SLOTS-1:0]               q_v;
    logic [QUEUES-1:0][SLOTS-1:0][TAG_W-1:0]    q_tag;
    logic [QUEUES-1:0][SLOTS-1:0][CNT_W-1:0]    q_cnt;
    logic [QUEUES-1:0][SLOTS-1:0][STAMP_W-1:0]  q_stamp;
    rec_t [QUEUES-1:0][SLOTS-1:0][MAXW-1:0]     q_rec;
    logic [QIDX_W-1:0]                          gq;
    logic [SLOT_W-1:0]                          gs;

    assign gq = gnt_idx[ENT_W-1:SLOT_W];
    assign gs = gnt_idx[SLOT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) stamp <= '0;
        else     stamp <= stamp + STAMP_W'(1);
    end

    iwc_route u_route (
        .in_valid (in_valid),
        .in_line  (in_line),
        .q_any    (q_any),
        .q_sel    (q_sel),
        .win      (win)
    );

    for (genvar q = 0; q < QUEUES; q++) begin : g_q
        req_t q_req;
        always_comb begin
            q_req.tag      = tag_of(in_line[q_sel[q]]);
            q_req.rec.warp = in_warp[q_sel[q]];
            q_req.rec.mask = in_mask[q_sel[q]];
        end
        iwc_queue u_queue (
            .clk       (clk),
            .rst       (rst),
            .req_valid (q_any[q]),
            .req       (q_req),
            .gnt_valid (gnt_valid && gq == QIDX_W'(q)),
            .gnt_slot  (gs),
            .stamp_now (stamp),
            .req_ok    (q_ok[q]),
            .ent_v     (q_v[q]),
            .ent_tag   (q_tag[q]),
            .ent_cnt   (q_cnt[q]),
            .ent_stamp (q_stamp[q]),
            .ent_rec   (q_rec[q])
        );
    end

    always_comb begin
        for (int p = 0; p < int'(PORTS); p++) begin
            in_ready[p] = win[p] && q_ok[qidx_of(in_line[p])];
        end
    end

    assign ent_valid = q_v;
    assign ent_stamp = q_stamp;
    always_comb begin
        for (int q = 0; q < int'(QUEUES); q++) begin
            for (int s = 0; s < int'(SLOTS); s++) begin
                ent_line[q*int'(SLOTS) + s] = {q_tag[q][s], QIDX_W'(q)};
            end
        end
    end

    always_comb begin
        out_valid = gnt_valid && q_v[gq][gs];
        out_line  = {q_tag[gq][gs], gq};
        out_count = q_cnt[gq][gs];
        for (int k = 0; k < int'(MAXW); k++) begin
            out_warp[k] = q_rec[gq][gs][k].warp;
            out_mask[k] = q_rec[gq][gs][k].mask;
        end
    end

    // R8: ready only with a request present
    assert_ready_valid_R8: assert property (@(posedge clk) disable iff (rst)
        (in_ready & ~in_valid) == '0);

    // R5: two accepted ports never share a queue
    for (genvar a = 0; a < PORTS; a++) begin : g_pa
        for (genvar b = a + 1; b < PORTS; b++) begin : g_pb
            assert_one_per_queue_R5: assert property (@(posedge clk) disable iff (rst)
                (in_ready[a] && in_ready[b]) |-> (qidx_of(in_line[a]) != qidx_of(in_line[b])));
        end
    end

    // R9: a granted entry is gone after the edge
    assert_grant_clears_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !ent_valid[$past(gnt_idx)]);

    // R12: stamp advances by one every cycle
    assert_stamp_step_R12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stamp == $past(stamp) + STAMP_W'(1));
endmodule

// File: tb/iwc_coalescer_bench.sv
module iwc_coalescer_bench;
    import iwc_pkg::*;

    logic                             clk = 1'b0;
    logic                             rst = 1'b1;
    logic [PORTS-1:0]                 in_valid = '0;
    logic [PORTS-1:0][LINE_W-1:0]     in_line  = '0;
    logic [PORTS-1:0][WID_W-1:0]      in_warp  = '0;
    logic [PORTS-1:0][LANES-1:0]      in_mask  = '0;
    logic [PORTS-1:0]                 in_ready;
    logic [ENTRIES-1:0]               ent_valid;
    logic [ENTRIES-1:0][LINE_W-1:0]   ent_line;
    logic [ENTRIES-1:0][STAMP_W-1:0]  ent_stamp;
    logic                             gnt_valid = 1'b0;
    logic [ENT_W-1:0]                 gnt_idx = '0;
    logic                             out_valid;
    logic [LINE_W-1:0]                out_line;
    logic [CNT_W-1:0]                 out_count;
    logic [MAXW-1:0][WID_W-1:0]       out_warp;
    logic [MAXW-1:0][LANES-1:0]       out_mask;

    iwc_coalescer u_iwc_coalescer (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit           valid;
        int unsigned  line;
        int unsigned  cnt;
        int unsigned  warp [MAXW];
        logic [31:0]  mask [MAXW];
    } exp_t;

    exp_t model [ENTRIES];
    exp_t sb [$];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input int p, input int unsigned line, input int unsigned warp, input logic [31:0] mask);
        in_valid[p] = 1'b1;
        in_line[p]  = LINE_W'(line);
        in_warp[p]  = WID_W'(warp);
        in_mask[p]  = mask;
    endtask

    task automatic model_add(input int idx, input int unsigned line, input int unsigned warp, input logic [31:0] mask);
        if (!model[idx].valid) begin
            model[idx].valid = 1'b1;
            model[idx].line  = line;
            model[idx].cnt   = 0;
        end
        model[idx].warp[model[idx].cnt] = warp;
        model[idx].mask[model[idx].cnt] = mask;
        model[idx].cnt++;
    endtask

    // Driver side: grant an entry and push what should come out.
    task automatic grant(input int idx);
        gnt_valid = 1'b1;
        gnt_idx   = ENT_W'(idx);
        sb.push_back(model[idx]);
        model[idx].valid = 1'b0;
        model[idx].cnt   = 0;
    endtask

    // Monitor: compares granted output against the scoreboard.
    always @(negedge clk) begin
        #2;
        if (gnt_valid && !done) begin
            exp_t e;
            e = sb.pop_front();
            check(out_valid == e.valid, "R9/R10 out_valid", longint'(out_valid), longint'(e.valid));
            if (e.valid) begin
                check(out_line == LINE_W'(e.line), "R9 out_line", longint'(out_line), longint'(e.line));
                check(out_count == CNT_W'(e.cnt), "R9/R11 out_count", longint'(out_count), longint'(e.cnt));
                for (int k = 0; k < int'(e.cnt); k++) begin
                    check(out_warp[k] == WID_W'(e.warp[k]), "R3/R9 out_warp", longint'(out_warp[k]), longint'(e.warp[k]));
                    check(out_mask[k] == e.mask[k], "R3/R9 out_mask", longint'(out_mask[k]), longint'(e.mask[k]));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        longint s1;
        foreach (model[i]) begin
            model[i].valid = 1'b0;
            model[i].cnt   = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: empty after reset, grant sees nothing
        check(ent_valid == '0, "R1 ent_valid", longint'(ent_valid[31:0]), 0);
        grant(0);
        step();
        gnt_valid = 1'b0;

        // R2/R4: allocate 0x0105 -> queue 5, slot 0, entry 10
        put(0, 16'h0105, 3, 32'h0000_000F);
        #1 check(in_ready[0] == 1'b1, "R8 ready on accept", longint'(in_ready[0]), 1);
        model_add(10, 16'h0105, 3, 32'h0000_000F);
        step();
        check(ent_valid[10] == 1'b1, "R4 alloc entry 10", longint'(ent_valid[10]), 1);
        check(ent_line[10] == 16'h0105, "R2 ent_line", longint'(ent_line[10]), 16'h0105);
        s1 = longint'(ent_stamp[10]);

        // R3 merge on port 0, R5 distinct queues both taken, R12 stamp gap
        put(0, 16'h0105, 7, 32'h0000_00F0);
        put(1, 16'h0207, 9, 32'hFFFF_0000);
        #1 check(in_ready == 2'b11, "R5 distinct queues", longint'(in_ready), 3);
        model_add(10, 16'h0105, 7, 32'h0000_00F0);
        model_add(14, 16'h0207, 9, 32'hFFFF_0000);
        step();
        check(ent_valid[11] == 1'b0, "R3 no new entry on merge", longint'(ent_valid[11]), 0);
        check(ent_valid[14] == 1'b1, "R4 alloc entry 14", longint'(ent_valid[14]), 1);
        check(longint'(ent_stamp[14]) - s1 == 1, "R12 stamp gap", longint'(ent_stamp[14]) - s1, 1);

        // R5: both ports into queue 5, lower port wins
        put(0, 16'h0305, 1, 32'h0000_0001);
        put(1, 16'h0405, 2, 32'h0000_0002);
        #1 check(in_ready == 2'b01, "R5 lower port wins", longint'(in_ready), 1);
        model_add(11, 16'h0305, 1, 32'h0000_0001);
        step();
        check(ent_line[11] == 16'h0305, "R4 lowest free slot", longint'(ent_line[11]), 16'h0305);

        // R7: queue 5 full of tags, new tag stalls
        in_valid[0] = 1'b0;
        #1 check(in_ready[1] == 1'b0, "R7 no free tag", longint'(in_ready[1]), 0);
        check(in_ready[0] == 1'b0, "R8 no ready without valid", longint'(in_ready[0]), 0);
        step();
        check(ent_line[10] == 16'h0105 && ent_line[11] == 16'h0305, "R7 entries unchanged",
              longint'(ent_line[11]), 16'h0305);
        in_valid = '0;

        // fill entry 10 to four records, then R6
        put(0, 16'h0105, 4, 32'h0000_0F00);
        model_add(10, 16'h0105, 4, 32'h0000_0F00);
        step();
        put(0, 16'h0105, 5, 32'h0000_F000);
        model_add(10, 16'h0105, 5, 32'h0000_F000);
        step();
        put(0, 16'h0105, 6, 32'h000F_0000);
        #1 check(in_ready[0] == 1'b0, "R6 full entry stalls", longint'(in_ready[0]), 0);
        step();
        in_valid = '0;

        // R9 drains
        grant(10);
        step();
        check(ent_valid[10] == 1'b0, "R9 entry freed", longint'(ent_valid[10]), 0);
        grant(14);
        step();
        gnt_valid = 1'b0;

        // R11: grant entry 11 while its line is requested again
        grant(11);
        put(0, 16'h0305, 8, 32'h0000_0080);
        #1 check(in_ready[0] == 1'b1, "R11 request taken during grant", longint'(in_ready[0]), 1);
        model_add(10, 16'h0305, 8, 32'h0000_0080);
        step();
        gnt_valid = 1'b0;
        in_valid  = '0;
        check(ent_valid[10] == 1'b1 && ent_line[10] == 16'h0305, "R11 fresh entry",
              longint'(ent_line[10]), 16'h0305);
        check(ent_valid[11] == 1'b0, "R11 granted slot freed", longint'(ent_valid[11]), 0);
        grant(10);
        step();

        // R10: grant of an empty entry
        grant(40);
        step();
        gnt_valid = 1'b0;
        #1 check(ent_valid == '0, "R10 no change", longint'(ent_valid[31:0]), 0);
        step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule